// File: doc/BRIEF.md
# Transport-Triggered Move Socket

This block attaches one function unit to a transport-triggered interconnect made of four move buses. Each bus carries a 24-bit control word and a data word alongside it. Every cycle the socket looks at all four control words. It compares one socket-ID field in each word with its own elaborated ID. A socket in the input role compares the destination field. A socket in the output role compares the source field.

When a bus matches, the compare stage reports three things: which bus matched, an enable, and the opcode carried in that bus's control word. It also raises a conflict flag if more than one bus matched. The steering stage then acts according to the role. An input socket multiplexes the chosen bus's data onto the function unit's operand. An output socket demultiplexes the unit's result onto the chosen bus and drives zero on every other bus, so the drives of several sockets can be OR-combined.

A parameter can place a register between the compare and steering stages and a second register on all outputs. This trades two cycles of latency for a shorter combinational path.

Top module: `tta_move_socket`

## Requirements
- R1: Control word layout: bits 23:15 hold the destination socket ID, bits 14:6 hold the source socket ID and bits 5:0 hold the opcode. An input-role socket matches a bus only when that bus's destination field equals its socket ID.
- R2: An output-role socket matches a bus only when that bus's source field equals its socket ID. An ID that appears only in the destination field does not enable it.
- R3: `en_o` is 1 exactly when at least one of the four buses matches.
- R4: `sel_o` gives the index (0 to 3) of the lowest-numbered matching bus. It is 0 when no bus matches.
- R5: `opcode_o` equals bits 5:0 of the selected bus's control word. It is zero when no bus matches.
- R6: `conflict_o` is 1 exactly when two or more buses match in the same cycle.
- R7: Input role: `fu_operand_o` equals the data of the selected bus when enabled and zero otherwise. `bus_drive_o` is all zero.
- R8: Output role: `bus_drive_o` carries `fu_result_i` on the selected bus and zero on the other three buses. All buses are zero when nothing matches. `fu_operand_o` is zero.
- R9: A socket-ID field of all zeros means "no transport" and never produces a match.
- R10: With `REGISTERED`=0 the outputs follow the inputs in the same cycle. With `REGISTERED`=1 every output reflects the inputs that were present two rising clock edges earlier.
- R11: While `rst_n` is low, the registered outputs are all zero, even if the buses carry matching words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when registered) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 4x24 | Control word of each move bus |
| bus_data_i | input | 4xDATA_W | Data word of each move bus |
| fu_result_i | input | DATA_W | Function unit result (output role) |
| fu_operand_o | output | DATA_W | Operand to the function unit (input role) |
| bus_drive_o | output | 4xDATA_W | Per-bus drive, zero when not selected |
| sel_o | output | 2 | Index of the selected bus |
| en_o | output | 1 | A bus matched this transport |
| opcode_o | output | 6 | Opcode from the selected control word |
| conflict_o | output | 1 | More than one bus matched |

## Verification
Priority selection and conflict detection can happen in the same cycle. Whenever two or more buses carry the socket's ID together, the lowest bus must be steered while the conflict flag rises. The bench creates this case with directed vectors that place the ID on buses 1 and 3, and on all four buses. It also generates a sweep in which every subset of buses matches. Each result is compared with a model that scans the buses from index 0 upward, for both a same-cycle input socket and a two-stage output socket. The same control word also puts one socket's ID in the source field and the other socket's ID in the destination field, which shows that each role reads only its own field.

// File: rtl/tta_move_socket.sv
module tta_move_socket #(
  parameter logic [8:0] SOCKET_ID   = 9'h0A5,
  parameter int         DATA_W      = 16,
  parameter int         NUM_BUS     = 4,
  parameter bit         OUTPUT_ROLE = 1'b0,
  parameter bit         REGISTERED  = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BUS-1:0][23:0]        ctrl_i,
  input  logic [NUM_BUS-1:0][DATA_W-1:0]  bus_data_i,
  input  logic [DATA_W-1:0]               fu_result_i,
  output logic [DATA_W-1:0]               fu_operand_o,
  output logic [NUM_BUS-1:0][DATA_W-1:0]  bus_drive_o,
  output logic [$clog2(NUM_BUS)-1:0]      sel_o,
  output logic                            en_o,
  output logic [5:0]                      opcode_o,
  output logic                            conflict_o
);
  localparam int SEL_W  = $clog2(NUM_BUS);
  localparam int DST_HI = 23;
  localparam int DST_LO = 15;
  localparam int SRC_HI = 14;
  localparam int SRC_LO = 6;
  localparam int OP_W   = 6;

  // compare stage
  logic [NUM_BUS-1:0] hit;
  logic [SEL_W-1:0]   c_sel;
  logic               c_en;
  logic [OP_W-1:0]    c_op;
  logic               c_conf;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_cmp
    logic [8:0] field;
    assign field  = OUTPUT_ROLE ? ctrl_i[b][SRC_HI:SRC_LO] : ctrl_i[b][DST_HI:DST_LO];
    assign hit[b] = (field == SOCKET_ID) && (|field);
  end

  always_comb begin
    c_sel = '0;
    for (int b = NUM_BUS - 1; b >= 0; b--)
      if (hit[b]) c_sel = SEL_W'(b);
  end

  assign c_en   = |hit;
  assign c_op   = c_en ? ctrl_i[c_sel][OP_W-1:0] : '0;
  assign c_conf = (hit & (hit - NUM_BUS'(1))) != '0;

  // optional boundary between the stages
  logic [SEL_W-1:0]                s_sel;
  logic                            s_en;
  logic [OP_W-1:0]                 s_op;
  logic                            s_conf;
  logic [NUM_BUS-1:0][DATA_W-1:0]  s_data;
  logic [DATA_W-1:0]               s_res;

  if (REGISTERED) begin : g_mid_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s_sel  <= '0;
        s_en   <= 1'b0;
        s_op   <= '0;
        s_conf <= 1'b0;
        s_data <= '0;
        s_res  <= '0;
      end else begin
        s_sel  <= c_sel;
        s_en   <= c_en;
        s_op   <= c_op;
        s_conf <= c_conf;
        s_data <= bus_data_i;
        s_res  <= fu_result_i;
      end
  end else begin : g_mid_wire
    assign s_sel  = c_sel;
    assign s_en   = c_en;
    assign s_op   = c_op;
    assign s_conf = c_conf;
    assign s_data = bus_data_i;
    assign s_res  = fu_result_i;
  end

  // steering stage
  logic [DATA_W-1:0]              n_operand;
  logic [NUM_BUS-1:0][DATA_W-1:0] n_drive;

  assign n_operand = (!OUTPUT_ROLE && s_en) ? s_data[s_sel] : '0;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_demux
    assign n_drive[b] = (OUTPUT_ROLE && s_en && s_sel == SEL_W'(b)) ? s_res : '0;
  end

  if (REGISTERED) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        fu_operand_o <= '0;
        bus_drive_o  <= '0;
        sel_o        <= '0;
        en_o         <= 1'b0;
        opcode_o     <= '0;
        conflict_o   <= 1'b0;
      end else begin
        fu_operand_o <= n_operand;
        bus_drive_o  <= n_drive;
        sel_o        <= s_sel;
        en_o         <= s_en;
        opcode_o     <= s_op;
        conflict_o   <= s_conf;
      end
  end else begin : g_out_wire
    assign fu_operand_o = n_operand;
    assign bus_drive_o  = n_drive;
    assign sel_o        = s_sel;
    assign en_o         = s_en;
    assign opcode_o     = s_op;
    assign conflict_o   = s_conf;
  end

  // checks
  logic [NUM_BUS-1:0] drv_nz;
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_nz
    assign drv_nz[b] = |bus_drive_o[b];
  end

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_en |-> (hit[c_sel] && ((hit & ((NUM_BUS'(1) << c_sel) - NUM_BUS'(1))) == '0)));

  assert_idle_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (opcode_o == '0));

  assert_conflict_has_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> en_o);

  assert_idle_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (fu_operand_o == '0));

  assert_single_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_nz));

  assert_idle_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (drv_nz == '0));
endmodule

// File: tb/test_tta_move_socket.sv
`timescale 1ns/1ps
module test_tta_move_socket;
  localparam int NB = 4;
  localparam int DW = 16;
  localparam logic [8:0] ID_IN  = 9'h0A5;
  localparam logic [8:0] ID_OUT = 9'h13C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0][23:0]   ctrl = '0;
  logic [NB-1:0][DW-1:0] data = '0;
  logic [DW-1:0]         res  = '0;

  logic [DW-1:0] a_oper, b_oper;
  logic [NB-1:0][DW-1:0] a_drv, b_drv;
  logic [1:0] a_sel, b_sel;
  logic a_en, b_en, a_conf, b_conf;
  logic [5:0] a_op, b_op;

  always #2 clk = ~clk;

  tta_move_socket #(.SOCKET_ID(ID_IN), .DATA_W(DW), .NUM_BUS(NB),
                    .OUTPUT_ROLE(1'b0), .REGISTERED(1'b0)) i_tta_move_socket (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .bus_data_i(data), .fu_result_i(res),
    .fu_operand_o(a_oper), .bus_drive_o(a_drv), .sel_o(a_sel), .en_o(a_en),
    .opcode_o(a_op), .conflict_o(a_conf));

  tta_move_socket #(.SOCKET_ID(ID_OUT), .DATA_W(DW), .NUM_BUS(NB),
                    .OUTPUT_ROLE(1'b1), .REGISTERED(1'b1)) i_tta_move_socket_reg (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .bus_data_i(data), .fu_result_i(res),
    .fu_operand_o(b_oper), .bus_drive_o(b_drv), .sel_o(b_sel), .en_o(b_en),
    .opcode_o(b_op), .conflict_o(b_conf));

  typedef struct {
    logic [1:0]            sel;
    logic                  en;
    logic [5:0]            op;
    logic                  conf;
    logic [DW-1:0]         oper;
    logic [NB-1:0][DW-1:0] drive;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  function automatic logic [23:0] word(logic [8:0] dst, logic [8:0] src, logic [5:0] op);
    return {dst, src, op};
  endfunction

  function automatic exp_t model(logic [NB-1:0][23:0] c, logic [NB-1:0][DW-1:0] d,
                                 logic [DW-1:0] r, bit use_src, logic [8:0] id);
    exp_t e;
    int cnt = 0;
    e.sel = '0; e.op = '0; e.oper = '0; e.drive = '0;
    for (int b = 0; b < NB; b++) begin
      logic [8:0] f;
      f = use_src ? c[b][14:6] : c[b][23:15];
      if (f == id && f != 9'd0) begin
        if (cnt == 0) begin e.sel = 2'(b); e.op = c[b][5:0]; end
        cnt++;
      end
    end
    e.en = cnt > 0;
    e.conf = cnt > 1;
    if (e.en && !use_src) e.oper = d[e.sel];
    if (e.en && use_src) e.drive[e.sel] = r;
    return e;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_now(logic [NB-1:0][23:0] c, logic [NB-1:0][DW-1:0] d, logic [DW-1:0] r);
    exp_t e;
    ctrl = c; data = d; res = r;
    sb.push_back(model(c, d, r, 1'b1, ID_OUT));
    e = model(c, d, r, 1'b0, ID_IN);
    #1;
    chk("R4 input sel", 64'(a_sel), 64'(e.sel));
    chk("R1/R3 input en", 64'(a_en), 64'(e.en));
    chk("R5 input opcode", 64'(a_op), 64'(e.op));
    chk("R6 input conflict", 64'(a_conf), 64'(e.conf));
    chk("R7 input operand", 64'(a_oper), 64'(e.oper));
    chk("R7 input drive zero", 64'(a_drv), 64'(0));
  endtask

  task automatic apply(logic [NB-1:0][23:0] c, logic [NB-1:0][DW-1:0] d, logic [DW-1:0] r);
    @(negedge clk);
    drive_now(c, d, r);
  endtask

  // monitor: registered output socket, two edges of latency (R10)
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() >= 2) begin
      exp_t e;
      e = sb.pop_front();
      chk("R10/R4 output sel", 64'(b_sel), 64'(e.sel));
      chk("R2/R3 output en", 64'(b_en), 64'(e.en));
      chk("R5 output opcode", 64'(b_op), 64'(e.op));
      chk("R6 output conflict", 64'(b_conf), 64'(e.conf));
      chk("R8 output drive", 64'(b_drv), 64'(e.drive));
      chk("R8 output operand zero", 64'(b_oper), 64'(0));
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; failed++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    logic [NB-1:0][23:0] c;
    logic [NB-1:0][DW-1:0] d;
    d = {16'hD333, 16'hC222, 16'hB111, 16'hA000};

    // R11: matching traffic during reset leaves registered outputs at zero
    ctrl = {word(ID_IN, ID_OUT, 6'h11), word(ID_IN, ID_OUT, 6'h22),
            word(ID_IN, ID_OUT, 6'h33), word(ID_IN, ID_OUT, 6'h3F)};
    data = d; res = 16'hBEEF;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset en", 64'(b_en), 64'(0));
    chk("R11 reset opcode", 64'(b_op), 64'(0));
    chk("R11 reset conflict", 64'(b_conf), 64'(0));
    chk("R11 reset drive", 64'(b_drv), 64'(0));

    @(negedge clk);
    rst_n = 1'b1;
    // R9: all-zero ID fields never match
    drive_now('0, d, 16'h1234);

    // R1: single destination match on bus 2
    c = {word(9'h001, 9'h002, 6'h01), word(ID_IN, 9'h003, 6'h2B),
         word(9'h004, 9'h005, 6'h02), word(9'h006, 9'h007, 6'h03)};
    apply(c, d, 16'h5A5A);

    // R4/R6: buses 1 and 3 match both roles
    c = {word(ID_IN, ID_OUT, 6'h31), word(9'h010, 9'h011, 6'h05),
         word(ID_IN, ID_OUT, 6'h17), word(9'h012, 9'h013, 6'h06)};
    apply(c, d, 16'h0F0F);

    // all four buses match
    c = {word(ID_IN, ID_OUT, 6'h04), word(ID_IN, ID_OUT, 6'h03),
         word(ID_IN, ID_OUT, 6'h02), word(ID_IN, ID_OUT, 6'h01)};
    apply(c, d, 16'h8001);

    // R1/R2: each ID in the other role's field only
    c = {word(ID_OUT, ID_IN, 6'h2A), word(ID_OUT, ID_IN, 6'h15),
         word(9'h020, 9'h021, 6'h07), word(9'h022, 9'h023, 6'h08)};
    apply(c, d, 16'h7777);

    // R2: output ID in source of bus 0, input ID in destination of same word
    c = {word(9'h030, 9'h031, 6'h09), word(9'h032, 9'h033, 6'h0A),
         word(9'h034, 9'h035, 6'h0B), word(ID_IN, ID_OUT, 6'h3C)};
    apply(c, d, 16'hFFFF);

    // sweep over every match subset for both roles
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < NB; b++) begin
        logic [8:0] dst, src;
        dst = ((k >> b) & 1) != 0 ? ID_IN : 9'(k * 7 + b + 1);
        src = ((k >> (3 - b)) & 1) != 0 ? ID_OUT : 9'(k * 5 + b + 2);
        c[b] = word(dst, src, 6'(k * 4 + b));
        d[b] = 16'(k * 16'h0101 + b * 16'h1001);
      end
      apply(c, d, 16'(16'hC000 + k));
    end

    // drain the registered pipeline with idle transports
    repeat (3) apply('0, '0, '0);
    @(negedge clk);
    report();
  end
endmodule